// File: doc/BRIEF.md
# Two-Digit Hex Display Driver with Binary Sum

This block shows two 4-bit values as hexadecimal characters on a two-digit common-anode seven-segment display. The two digits share one set of seven segment lines. Each digit has its own power-enable line. The block powers the two digits in turn, quickly enough that both appear lit at once. One combinational hex-to-segment decoder serves both digits. A selector in front of it picks the value that belongs to the digit being powered.

The block also drives a 5-bit binary output with the unsigned sum of the two values, for five discrete LEDs. The refresh rate is set by the parameter `REFRESH_DIV`, the number of clock cycles each digit stays lit. On a 25 MHz clock, any value up to about 200 000 keeps each digit refreshed at 60 Hz or faster. A bench can set it to a few cycles.

Top module: `hexpair_display`

## Requirements
- R1: While reset is held, and in the first cycle after the internal reset releases, `dig_en_n` equals 2'b10. That is, digit 0 (bit 0) is powered and digit 1 is dark.
- R2: At every clock cycle out of reset, exactly one bit of `dig_en_n` is low. The enables are active-low.
- R3: Once running, the powered digit stays the same for exactly `REFRESH_DIV` clock cycles and then changes.
- R4: `seg_n` always shows the pattern for the value of the digit currently powered: `val_lo` when digit 0 is powered, `val_hi` when digit 1 is powered. The segment lines and the enables switch on the same clock edge.
- R5: Segments are active-low, with bit order {g,f,e,d,c,b,a} (bit 0 drives a). The `seg_n` codes for values 0 to F are: 40, 79, 24, 30, 19, 12, 02, 78, 00, 10, 08, 03, 46, 21, 06, 0E (hex).
- R6: `sum_led` equals the 5-bit unsigned sum `val_lo + val_hi` at all times. It does not depend on which digit is powered.
- R7: Each change of the powered digit swaps the two enable bits, so the digits alternate 0, 1, 0, 1, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| val_lo | input | 4 | Value shown on digit 0 |
| val_hi | input | 4 | Value shown on digit 1 |
| seg_n | output | 7 | Shared active-low segment lines {g,f,e,d,c,b,a} |
| dig_en_n | output | 2 | Active-low digit power enables, bit 0 = digit 0 |
| sum_led | output | 5 | Binary sum of the two values |

## Verification
A refresh counter that has drifted or wrapped at the wrong count shows at the ports as a dwell that is too long or too short. The bench sees this at the first enable change after the fault.

A stuck or mis-steered select bit shows in one of two ways. If the enable is wrong, one digit stays powered past `REFRESH_DIV` cycles. If the selector is wrong, the segment lines show the other digit's value in the very cycle the enable changes.

Because every pair of input values is swept, a corrupted decoder entry or a carry fault in the adder appears at the ports as soon as the bad value is applied.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;
  localparam int NIB_W = 4;
  localparam int SEG_W = 7;
  localparam int SUM_W = NIB_W + 1;
  localparam int DIGITS = 2;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [SEG_W-1:0] seg_t;

  // Active-high lit pattern, bit order {g,f,e,d,c,b,a}; inverted for common anode.
  function automatic seg_t hex_to_seg_n(input nib_t v);
    seg_t lit;
    case (v)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction
endpackage

// File: rtl/reset_sync.sv
module reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int REFRESH_DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (REFRESH_DIV > 2) ? $clog2(REFRESH_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFRESH_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  // R3: counter stays in range, phase holds until terminal count, then flips
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> $stable(phase_q));
  a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/digit_seg_mux.sv
module digit_seg_mux
  import hexdisp_pkg::*;
(
  input  logic phase,
  input  nib_t val_lo,
  input  nib_t val_hi,
  output seg_t seg_n,
  output logic [DIGITS-1:0] dig_en_n
);
  nib_t pick;

  always_comb begin
    pick     = phase ? val_hi : val_lo;
    seg_n    = hex_to_seg_n(pick);
    dig_en_n = phase ? 2'b01 : 2'b10;
  end
endmodule

// File: rtl/sum_unit.sv
module sum_unit
  import hexdisp_pkg::*;
(
  input  nib_t a,
  input  nib_t b,
  output logic [SUM_W-1:0] sum
);
  assign sum = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/hexpair_display.sv
module hexpair_display
  import hexdisp_pkg::*;
#(
  parameter int REFRESH_DIV = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] val_lo,
  input  logic [3:0] val_hi,
  output logic [6:0] seg_n,
  output logic [1:0] dig_en_n,
  output logic [4:0] sum_led
);
  logic rst_n_s;
  logic phase;

  reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  refresh_timer #(.REFRESH_DIV(REFRESH_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .phase(phase)
  );

  digit_seg_mux u_mux (
    .phase(phase), .val_lo(val_lo), .val_hi(val_hi),
    .seg_n(seg_n), .dig_en_n(dig_en_n)
  );

  sum_unit u_sum (
    .a(val_lo), .b(val_hi), .sum(sum_led)
  );

  // R2: exactly one digit powered
  a_r2_one_enable: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(~dig_en_n) == 1);
  // R7: every enable change is a swap
  a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(dig_en_n) |-> (dig_en_n == ~$past(dig_en_n)));
  // R6: sum unaffected by multiplex phase
  a_r6_phase_free: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($stable(val_lo) && $stable(val_hi)) |-> $stable(sum_led));
endmodule

// File: tb/hexpair_display_test.sv
module hexpair_display_test;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] val_lo, val_hi;
  logic [6:0] seg_n;
  logic [1:0] dig_en_n;
  logic [4:0] sum_led;

  int total = 0;
  int bad = 0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  hexpair_display #(.REFRESH_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .val_lo(val_lo), .val_hi(val_hi),
    .seg_n(seg_n), .dig_en_n(dig_en_n), .sum_led(sum_led)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                           7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
    return t[v];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Dwell (R3) and alternation (R7) tracking
  logic [1:0] prev_en;
  int run_len;
  bit seen_swap;
  always @(negedge clk) begin
    if (running) begin
      if (dig_en_n != prev_en) begin
        check(dig_en_n == {prev_en[0], prev_en[1]}, "R7", dig_en_n, {prev_en[0], prev_en[1]});
        if (seen_swap) check(run_len == DIV, "R3", run_len, DIV);
        seen_swap = 1'b1;
        run_len = 1;
      end else begin
        run_len++;
      end
      prev_en = dig_en_n;
    end
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    val_lo = 4'h3;
    val_hi = 4'hC;
    repeat (3) @(negedge clk);
    check(dig_en_n == 2'b10, "R1", dig_en_n, 2'b10);
    check(seg_n == exp_seg(4'h3), "R4", seg_n, exp_seg(4'h3));
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(dig_en_n == 2'b10, "R1", dig_en_n, 2'b10);
    prev_en = dig_en_n;
    run_len = 1;
    seen_swap = 1'b0;
    running = 1'b1;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        val_lo = 4'(a);
        val_hi = 4'(b);
        for (int c = 0; c < 2*DIV; c++) begin
          @(negedge clk);
          #0.5;
          check($countones(~dig_en_n) == 1, "R2", dig_en_n, 1);
          check(int'(sum_led) == a + b, "R6", sum_led, a + b);
          if (dig_en_n == 2'b10)
            check(seg_n == exp_seg(4'(a)), "R4/R5 digit0", seg_n, exp_seg(4'(a)));
          else
            check(seg_n == exp_seg(4'(b)), "R4/R5 digit1", seg_n, exp_seg(4'(b)));
        end
      end
    end
    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule